// File: doc/BRIEF.md
# Configurable Async Character Framer

This block is the character layer of a low-rate serial modem data path. A transmit engine takes a byte from a one-entry holding register and sends it as an asynchronous character: a low start bit, seven or eight data bits with the least significant bit first, an optional parity bit and one or two high stop bits. A receive engine recovers characters of the same format from a serial input and places each one in a receive holding register. Both engines are paced by a single enable pulse at sixteen times the bit rate. Each bit lasts sixteen pulses, and the receiver takes each bit at its centre.

The framer drives one-cycle status pulses that a separate flags register can collect: transmit underflow, receive ready, receive overflow and bad parity. It also gives two levels: transmit holding register empty and receive holding register full. The character format comes from four static control inputs, which must not change while a character is in flight. Modulation, clock recovery and synchronous operation are done elsewhere.

Top module: `afr_top`

## Requirements
- R1: After reset the transmit line is high, tx_ready is 1, rx_full is 0, rx_byte is 0 and no status pulse is asserted.
- R2: A transmitted character is one low start bit, then cfg_len7 ? 7 : 8 data bits least significant bit first, then an optional parity bit, then cfg_stop2 ? 2 : 1 high stop bits. Every bit lasts 16 tick_16x pulses.
- R3: With cfg_par_en = 1 a parity bit follows the data. With cfg_par_even = 1 the count of ones over data plus parity is even, and with cfg_par_even = 0 it is odd. With cfg_par_en = 0 no parity bit is sent or expected.
- R4: tx_ready is 1 exactly when the transmit holding register is empty. A tx_wr while tx_ready is 0 is ignored. A byte that is waiting when the last stop bit ends starts at once, with no idle gap and no underflow.
- R5: When the last stop bit ends and the holding register is empty, tx_underflow pulses for one cycle and the line stays high until a new byte is written. No underflow is reported from the idle state after reset.
- R6: When the receiver takes the first stop bit of a character, rx_ready pulses for one cycle, rx_byte holds the data and rx_full goes to 1. In 7-bit mode rx_byte bit 7 reads 0.
- R7: rx_bad_par pulses together with rx_ready when parity is enabled and the received parity bit breaks the selected sense.
- R8: If a character completes while rx_full is 1 and rx_rd is not asserted in that cycle, rx_overrun pulses with rx_ready and the new byte replaces the old one.
- R9: A low level on the idle line that is no longer low eight pulses after it is seen is discarded as a glitch. Nothing is received and rx_full does not change.
- R10: rx_rd clears rx_full on the next clock, unless a character completes in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_16x | input | 1 | Enable pulse at 16 times the bit rate |
| cfg_len7 | input | 1 | 0: 8 data bits, 1: 7 data bits |
| cfg_par_en | input | 1 | 0: no parity, 1: parity bit present |
| cfg_par_even | input | 1 | 0: odd parity, 1: even parity |
| cfg_stop2 | input | 1 | 0: one stop bit, 1: two stop bits |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_byte | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Transmit holding register empty |
| tx_underflow | output | 1 | One-cycle pulse: character ended with nothing to send |
| tx_line | output | 1 | Serial transmit output, idles high |
| rx_line | input | 1 | Serial receive input, idles high |
| rx_rd | input | 1 | Read strobe, clears rx_full |
| rx_byte | output | 8 | Receive holding register |
| rx_full | output | 1 | Receive holding register holds an unread byte |
| rx_ready | output | 1 | One-cycle pulse: character received |
| rx_bad_par | output | 1 | One-cycle pulse with rx_ready on parity mismatch |
| rx_overrun | output | 1 | One-cycle pulse with rx_ready when an unread byte was overwritten |

## Verification
A bit counter or shift register that drifts in the transmitter shows on tx_line within one bit time, 16 ticks. It appears as a missing bit, a bit in the wrong place or a wrong stop length, and a mid-bit sample of the whole frame exposes it. The same fault in the receiver shows at the first stop bit, as a wrong rx_byte or a missing or false rx_ready. A wrong parity or overrun decision shows in the pulses that come with rx_ready in that cycle. A holding-register flag that is stuck shows as a missing or extra underflow, or a missing or extra frame, within one character time.

// File: rtl/afr_pkg.sv
package afr_pkg;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_PAR,
        FR_STOP
    } afr_state_e;

    typedef struct packed {
        logic len7;
        logic par_en;
        logic par_even;
        logic stop2;
    } afr_cfg_t;

endpackage

// File: rtl/afr_tx.sv
module afr_tx
    import afr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  afr_cfg_t          cfg,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              line,
    output logic              ready,
    output logic              underflow
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_END    = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] LAST_FULL  = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(DATA_W - 2);

    typedef struct packed {
        afr_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic              stop_n;
        logic [DATA_W-1:0] shf;
        logic              par;
        logic [DATA_W-1:0] hold;
        logic              hold_v;
        logic              line;
        logic              udf;
    } tx_s;

    tx_s q, d;

    logic [DATA_W-1:0] msk;
    logic [IDX_W-1:0]  last_idx;
    logic              bit_end;
    logic              start_chr;

    assign msk      = cfg.len7 ? {1'b0, {(DATA_W-1){1'b1}}} : {DATA_W{1'b1}};
    assign last_idx = cfg.len7 ? LAST_SHORT : LAST_FULL;
    assign bit_end  = tick && (q.cnt == CNT_END);

    always_comb begin
        d         = q;
        d.udf     = 1'b0;
        start_chr = 1'b0;

        if (wr && !q.hold_v) begin
            d.hold   = wdata;
            d.hold_v = 1'b1;
        end

        if (tick && q.st != FR_IDLE) begin
            d.cnt = bit_end ? '0 : q.cnt + CNT_W'(1);
        end

        case (q.st)
            FR_IDLE: begin
                d.cnt  = '0;
                d.line = 1'b1;
                if (tick && q.hold_v) begin
                    start_chr = 1'b1;
                end
            end
            FR_START: begin
                if (bit_end) begin
                    d.st   = FR_DATA;
                    d.idx  = '0;
                    d.line = q.shf[0];
                end
            end
            FR_DATA: begin
                if (bit_end) begin
                    if (q.idx == last_idx) begin
                        if (cfg.par_en) begin
                            d.st   = FR_PAR;
                            d.line = q.par;
                        end else begin
                            d.st     = FR_STOP;
                            d.stop_n = 1'b0;
                            d.line   = 1'b1;
                        end
                    end else begin
                        d.idx  = q.idx + IDX_W'(1);
                        d.shf  = q.shf >> 1;
                        d.line = q.shf[1];
                    end
                end
            end
            FR_PAR: begin
                if (bit_end) begin
                    d.st     = FR_STOP;
                    d.stop_n = 1'b0;
                    d.line   = 1'b1;
                end
            end
            FR_STOP: begin
                if (bit_end) begin
                    if (cfg.stop2 && !q.stop_n) begin
                        d.stop_n = 1'b1;
                    end else if (q.hold_v) begin
                        start_chr = 1'b1;
                    end else begin
                        d.st   = FR_IDLE;
                        d.udf  = 1'b1;
                        d.line = 1'b1;
                    end
                end
            end
            default: begin
                d.st   = FR_IDLE;
                d.line = 1'b1;
            end
        endcase

        if (start_chr) begin
            d.st     = FR_START;
            d.cnt    = '0;
            d.shf    = q.hold & msk;
            d.par    = (^(q.hold & msk)) ^ ~cfg.par_even;
            d.hold_v = 1'b0;
            d.line   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.line <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign line      = q.line;
    assign ready     = !q.hold_v;
    assign underflow = q.udf;

endmodule

// File: rtl/afr_rx.sv
module afr_rx
    import afr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              len7,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              line,
    input  logic              rd,
    output logic [DATA_W-1:0] data,
    output logic              full,
    output logic              ready,
    output logic              bad_par,
    output logic              overrun
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_END    = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] CNT_HALF   = CNT_W'(OVS / 2 - 1);
    localparam logic [IDX_W-1:0] LAST_FULL  = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(DATA_W - 2);

    typedef struct packed {
        afr_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shf;
        logic              perr;
        logic [DATA_W-1:0] hold;
        logic              full;
        logic              rdy;
        logic              bp;
        logic              ovr;
    } rx_s;

    rx_s q, d;

    logic [DATA_W-1:0] msk;
    logic [DATA_W-1:0] mdata;
    logic [IDX_W-1:0]  last_idx;
    logic              bit_end;

    assign msk      = len7 ? {1'b0, {(DATA_W-1){1'b1}}} : {DATA_W{1'b1}};
    assign mdata    = q.shf & msk;
    assign last_idx = len7 ? LAST_SHORT : LAST_FULL;
    assign bit_end  = tick && (q.cnt == CNT_END);

    always_comb begin
        d     = q;
        d.rdy = 1'b0;
        d.bp  = 1'b0;
        d.ovr = 1'b0;

        if (rd) begin
            d.full = 1'b0;
        end

        if (tick && q.st != FR_IDLE) begin
            d.cnt = bit_end ? '0 : q.cnt + CNT_W'(1);
        end

        case (q.st)
            FR_IDLE: begin
                d.cnt  = '0;
                d.perr = 1'b0;
                if (tick && !line) begin
                    d.st = FR_START;
                end
            end
            FR_START: begin
                if (tick && q.cnt == CNT_HALF) begin
                    d.cnt = '0;
                    if (line) begin
                        d.st = FR_IDLE;
                    end else begin
                        d.st  = FR_DATA;
                        d.idx = '0;
                    end
                end
            end
            FR_DATA: begin
                if (bit_end) begin
                    d.shf[q.idx] = line;
                    if (q.idx == last_idx) begin
                        d.st = par_en ? FR_PAR : FR_STOP;
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                    end
                end
            end
            FR_PAR: begin
                if (bit_end) begin
                    d.perr = (^mdata) ^ line ^ ~par_even;
                    d.st   = FR_STOP;
                end
            end
            FR_STOP: begin
                if (bit_end) begin
                    d.hold = mdata;
                    d.rdy  = 1'b1;
                    d.bp   = q.perr;
                    d.ovr  = q.full && !rd;
                    d.full = 1'b1;
                    d.st   = FR_IDLE;
                end
            end
            default: begin
                d.st = FR_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign data    = q.hold;
    assign full    = q.full;
    assign ready   = q.rdy;
    assign bad_par = q.bp;
    assign overrun = q.ovr;

endmodule

// File: rtl/afr_top.sv
module afr_top
    import afr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_16x,
    input  logic              cfg_len7,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_stop2,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              tx_ready,
    output logic              tx_underflow,
    output logic              tx_line,
    input  logic              rx_line,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_full,
    output logic              rx_ready,
    output logic              rx_bad_par,
    output logic              rx_overrun
);
    afr_cfg_t cfg;

    assign cfg = '{len7: cfg_len7, par_en: cfg_par_en,
                   par_even: cfg_par_even, stop2: cfg_stop2};

    afr_tx #(.DATA_W(DATA_W), .OVS(OVS)) i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_16x),
        .cfg       (cfg),
        .wr        (tx_wr),
        .wdata     (tx_byte),
        .line      (tx_line),
        .ready     (tx_ready),
        .underflow (tx_underflow)
    );

    afr_rx #(.DATA_W(DATA_W), .OVS(OVS)) i_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_16x),
        .len7     (cfg_len7),
        .par_en   (cfg_par_en),
        .par_even (cfg_par_even),
        .line     (rx_line),
        .rd       (rx_rd),
        .data     (rx_byte),
        .full     (rx_full),
        .ready    (rx_ready),
        .bad_par  (rx_bad_par),
        .overrun  (rx_overrun)
    );

endmodule

// File: rtl/afr_chk.sv
module afr_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_wr,
    input logic tx_ready,
    input logic tx_line,
    input logic tx_underflow,
    input logic rx_rd,
    input logic rx_full,
    input logic rx_ready,
    input logic rx_bad_par,
    input logic rx_overrun
);
    // R4
    wr_takes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr && tx_ready |=> !tx_ready);

    // R5
    udf_idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underflow |-> tx_ready && tx_line);

    // R6
    ready_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> rx_full);

    // R7
    bad_par_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bad_par |-> rx_ready);

    // R8
    overrun_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> rx_ready);

    // R8
    overrun_when_unread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready && $past(rx_full) && !$past(rx_rd) |-> rx_overrun);

    // R10
    read_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd && !rx_ready |=> !rx_full || rx_ready);

endmodule

bind afr_top afr_chk i_afr_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_wr        (tx_wr),
    .tx_ready     (tx_ready),
    .tx_line      (tx_line),
    .tx_underflow (tx_underflow),
    .rx_rd        (rx_rd),
    .rx_full      (rx_full),
    .rx_ready     (rx_ready),
    .rx_bad_par   (rx_bad_par),
    .rx_overrun   (rx_overrun)
);

// File: tb/test_afr_top.sv
module test_afr_top;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLK  = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_16x;
    logic       cfg_len7 = 0, cfg_par_en = 0, cfg_par_even = 0, cfg_stop2 = 0;
    logic       tx_wr = 0;
    logic [7:0] tx_byte = 0;
    logic       tx_ready, tx_underflow, tx_line;
    logic       rx_line;
    logic       rx_rd = 0;
    logic [7:0] rx_byte;
    logic       rx_full, rx_ready, rx_bad_par, rx_overrun;
    logic       loop_sel = 1'b1;
    logic       rx_drv = 1'b1;
    int         tdiv = 0;

    int n_chk = 0, n_err = 0;
    int got_cnt = 0, ovr_cnt = 0, udf_cnt = 0;
    logic [7:0] last_byte = 0;
    logic       last_bp = 0;

    always #5 clk = ~clk;

    always @(posedge clk) tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    assign tick_16x = (tdiv == TICK_DIV - 1);
    assign rx_line  = loop_sel ? tx_line : rx_drv;

    afr_top i_afr_top (
        .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x),
        .cfg_len7(cfg_len7), .cfg_par_en(cfg_par_en),
        .cfg_par_even(cfg_par_even), .cfg_stop2(cfg_stop2),
        .tx_wr(tx_wr), .tx_byte(tx_byte), .tx_ready(tx_ready),
        .tx_underflow(tx_underflow), .tx_line(tx_line),
        .rx_line(rx_line), .rx_rd(rx_rd), .rx_byte(rx_byte),
        .rx_full(rx_full), .rx_ready(rx_ready),
        .rx_bad_par(rx_bad_par), .rx_overrun(rx_overrun)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_ready) begin
                got_cnt++;
                last_byte = rx_byte;
                last_bp   = rx_bad_par;
            end
            if (rx_overrun) ovr_cnt++;
            if (tx_underflow) udf_cnt++;
        end
    end

    // format bits {len7, par_en, par_even, stop2}, then data
    localparam logic [11:0] VEC [8] = '{
        {4'b0000, 8'hA5}, {4'b0001, 8'h3C}, {4'b0100, 8'hE7}, {4'b0111, 8'h5A},
        {4'b1000, 8'hFF}, {4'b1001, 8'h80}, {4'b1110, 8'hC3}, {4'b1101, 8'h7E}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    function automatic int build(input logic [3:0] c, input logic [7:0] dat,
                                 output logic [11:0] f);
        int n = c[3] ? 7 : 8;
        logic [7:0] m = c[3] ? (dat & 8'h7F) : dat;
        int k;
        f    = '1;
        f[0] = 1'b0;
        for (int i = 0; i < n; i++) f[1 + i] = m[i];
        k = 1 + n;
        if (c[2]) begin
            f[k] = (^m) ^ ~c[1];
            k++;
        end
        return k + (c[0] ? 2 : 1);
    endfunction

    task automatic set_cfg(input logic [3:0] c);
        @(negedge clk);
        {cfg_len7, cfg_par_en, cfg_par_even, cfg_stop2} = c;
    endtask

    task automatic write_tx(input logic [7:0] b);
        @(negedge clk);
        tx_byte = b;
        tx_wr   = 1'b1;
        @(negedge clk);
        tx_wr   = 1'b0;
    endtask

    task automatic read_rx();
        @(negedge clk);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic capture(input int nb, output logic [11:0] f);
        f = '1;
        while (tx_line !== 1'b0) @(negedge clk);
        repeat (BIT_CLK / 2) @(negedge clk);
        f[0] = tx_line;
        for (int i = 1; i < nb; i++) begin
            repeat (BIT_CLK) @(negedge clk);
            f[i] = tx_line;
        end
    endtask

    task automatic drive(input logic [11:0] f, input int nb);
        for (int i = 0; i < nb; i++) begin
            rx_drv = f[i];
            repeat (BIT_CLK) @(negedge clk);
        end
        rx_drv = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        logic [11:0] ef, af, ef2, af2;
        int nb, nb2, g0, o0, u0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (200) @(negedge clk);
        // R1 reset state
        chk(tx_line === 1'b1, "R1 tx_line", 32'(tx_line), 1);
        chk(tx_ready === 1'b1, "R1 tx_ready", 32'(tx_ready), 1);
        chk(rx_full === 1'b0, "R1 rx_full", 32'(rx_full), 0);
        chk(rx_byte === 8'h00, "R1 rx_byte", 32'(rx_byte), 0);
        // R5 no underflow from idle after reset
        chk(udf_cnt == 0, "R5 idle underflow", 32'(udf_cnt), 0);

        // table walk: loopback over all formats (R2 R3 R5 R6 R10)
        for (int v = 0; v < 8; v++) begin
            logic [3:0] c = VEC[v][11:8];
            logic [7:0] dat = VEC[v][7:0];
            logic [7:0] exp_b = c[3] ? (dat & 8'h7F) : dat;
            g0 = got_cnt; o0 = ovr_cnt; u0 = udf_cnt;
            set_cfg(c);
            nb = build(c, dat, ef);
            write_tx(dat);
            capture(nb, af);
            chk(af === ef, "R2 R3 tx frame", 32'(af), 32'(ef));
            repeat (BIT_CLK + 16) @(negedge clk);
            chk(got_cnt == g0 + 1, "R6 rx count", 32'(got_cnt - g0), 1);
            chk(last_byte === exp_b, "R6 rx byte", 32'(last_byte), 32'(exp_b));
            chk(last_bp === 1'b0, "R7 good parity", 32'(last_bp), 0);
            chk(udf_cnt == u0 + 1, "R5 underflow", 32'(udf_cnt - u0), 1);
            chk(tx_line === 1'b1, "R5 mark after underflow", 32'(tx_line), 1);
            chk(ovr_cnt == o0, "R8 no overrun", 32'(ovr_cnt - o0), 0);
            chk(rx_full === 1'b1, "R6 full", 32'(rx_full), 1);
            read_rx();
            chk(rx_full === 1'b0, "R10 read clears", 32'(rx_full), 0);
        end

        // R4 back-to-back, ignored write, R8 overrun in loopback
        set_cfg(4'b0000);
        g0 = got_cnt; o0 = ovr_cnt; u0 = udf_cnt;
        nb  = build(4'b0000, 8'h96, ef);
        nb2 = build(4'b0000, 8'h4B, ef2);
        write_tx(8'h96);
        fork
            capture(nb, af);
            begin
                while (tx_line !== 1'b0) @(negedge clk);
                write_tx(8'h4B);
                chk(tx_ready === 1'b0, "R4 hold full", 32'(tx_ready), 0);
                write_tx(8'hEE);
            end
        join
        chk(af === ef, "R4 first frame", 32'(af), 32'(ef));
        capture(nb2, af2);
        chk(af2 === ef2, "R4 second frame", 32'(af2), 32'(ef2));
        chk(udf_cnt == u0, "R4 no gap underflow", 32'(udf_cnt - u0), 0);
        repeat (6 * BIT_CLK) @(negedge clk);
        chk(udf_cnt == u0 + 1, "R5 underflow after pair", 32'(udf_cnt - u0), 1);
        chk(got_cnt == g0 + 2, "R4 ignored write", 32'(got_cnt - g0), 2);
        chk(tx_line === 1'b1, "R5 line mark", 32'(tx_line), 1);
        chk(ovr_cnt == o0 + 1, "R8 loopback overrun", 32'(ovr_cnt - o0), 1);
        chk(last_byte === 8'h4B, "R8 new byte kept", 32'(last_byte), 32'h4B);
        read_rx();

        // R7 injected parity error, 8 data bits even parity
        loop_sel = 1'b0;
        set_cfg(4'b0110);
        nb = build(4'b0110, 8'h55, ef);
        ef[9] = ~ef[9];
        g0 = got_cnt;
        drive(ef, nb);
        chk(got_cnt == g0 + 1, "R7 received", 32'(got_cnt - g0), 1);
        chk(last_bp === 1'b1, "R7 bad parity", 32'(last_bp), 1);
        chk(last_byte === 8'h55, "R7 byte", 32'(last_byte), 32'h55);
        read_rx();

        // R8 overrun with injected frames
        set_cfg(4'b0000);
        g0 = got_cnt; o0 = ovr_cnt;
        nb = build(4'b0000, 8'h11, ef);
        drive(ef, nb);
        chk(ovr_cnt == o0, "R8 first no overrun", 32'(ovr_cnt - o0), 0);
        nb = build(4'b0000, 8'h22, ef);
        drive(ef, nb);
        chk(ovr_cnt == o0 + 1, "R8 overrun", 32'(ovr_cnt - o0), 1);
        chk(rx_byte === 8'h22, "R8 replaced", 32'(rx_byte), 32'h22);
        chk(rx_full === 1'b1, "R8 still full", 32'(rx_full), 1);
        read_rx();
        chk(rx_full === 1'b0, "R10 cleared", 32'(rx_full), 0);

        // R9 glitch rejection
        g0 = got_cnt;
        @(negedge clk);
        rx_drv = 1'b0;
        repeat (4 * TICK_DIV) @(negedge clk);
        rx_drv = 1'b1;
        repeat (3 * BIT_CLK) @(negedge clk);
        chk(got_cnt == g0, "R9 glitch ignored", 32'(got_cnt - g0), 0);
        chk(rx_full === 1'b0, "R9 full unchanged", 32'(rx_full), 0);
        nb = build(4'b0000, 8'h3C, ef);
        drive(ef, nb);
        chk(last_byte === 8'h3C, "R9 next frame", 32'(last_byte), 32'h3C);

        // R6 seven-bit mode, bit 7 of line data forced high by driving 8 ones
        read_rx();
        set_cfg(4'b1000);
        nb = build(4'b1000, 8'h7F, ef);
        drive(ef, nb);
        chk(rx_byte === 8'h7F, "R6 bit7 zero", 32'(rx_byte), 32'h7F);

        report();
    end
endmodule